// File: doc/BRIEF.md
# External Bus Request and Parking Controller

This block sits between a processor core and an outside bus arbiter. It raises a bus request toward the arbiter whenever the core has an access pending for the external bus, and it follows the arbiter's grant to know whether the core currently owns that bus. A software hold bit can force the request on even when no access is pending. The same bit decides what the request does while the core is stopped or waiting: it is frozen at its last value, or it is dropped.

Ownership may last longer than the request. Once the core has been granted the bus, it stays master for as long as the grant stays high, even after the request has fallen. While the core is master but neither requesting nor accessing, the block reports the bus as parked. A new external access in that state is released at once through the go output, with no new arbitration round.

Accesses to the internal bus are taken in on their own pins only so that the separation is explicit. They never reach the request. No data passes through the block, so there is no valid/ready stream here: every pin is a plain level-sensitive control or status signal, and nothing applies back-pressure.

Top module: `brq_ctrl`

## Requirements
- R1: While `rst_n` is low, `bus_req`, `bus_master`, `bus_parked` and `xacc_go` are all 0. Reset is asynchronous, and the block starts as bus slave.
- R2: With `core_stop` and `core_wait` both low, `bus_req` in the cycle after each rising clock edge equals the OR of all `xacc_req` bits and `req_hold`, as sampled at that edge.
- R3: `iacc_req` has no effect on any output. With no external access pending, `req_hold` low and the core running, `bus_req` stays 0 whatever `iacc_req` carries.
- R4: With `req_hold` high and the core running, `bus_req` is 1 in the following cycle even when every `xacc_req` bit is 0.
- R5: If `core_stop` or `core_wait` is high and `req_hold` is low at a clock edge, `bus_req` is 0 after that edge.
- R6: If `core_stop` or `core_wait` is high and `req_hold` is high at a clock edge, `bus_req` keeps the value it had before that edge.
- R7: A clock edge that samples `bus_grant` high and `bus_req` high sets `bus_master` after that edge.
- R8: A clock edge that samples `bus_grant` low clears `bus_master` after that edge.
- R9: While `bus_grant` stays high, `bus_master` stays set when `bus_req` falls (parking).
- R10: `bus_parked` is 1 exactly when `bus_master` is 1, `bus_req` is 0 and no `xacc_req` bit is set, and it follows these in the same cycle.
- R11: `xacc_go` is 1 exactly when `bus_master` is 1 and at least one `xacc_req` bit is set, in the same cycle, so an access that arrives while parked goes ahead with no new request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| xacc_req | input | NUM_XSRC | External-bus access pending, one bit per core source |
| iacc_req | input | NUM_ISRC | Internal-bus access pending (no effect on the request) |
| req_hold | input | 1 | Software request-hold bit |
| bus_grant | input | 1 | Grant from the outside arbiter |
| core_stop | input | 1 | Core is in stop state |
| core_wait | input | 1 | Core is in wait state |
| bus_req | output | 1 | Bus request to the arbiter, active high |
| bus_master | output | 1 | Core currently owns the external bus |
| bus_parked | output | 1 | Owned bus with no request and no pending access |
| xacc_go | output | 1 | Pending external access may proceed now |

## Verification
The bench targets the moment the request falls while the grant is still high. A design without parking would drop master status there, and then fail to raise `xacc_go` when the next access arrives. It enters stop and wait with the hold bit both set and clear, to catch a request that is frozen when it should drop, or dropped when it should freeze. It also drives internal-bus traffic and the hold bit with no external access pending, to expose a request that is raised by the wrong source or that ignores the hold bit. A reset in the middle of a run checks that a master does not stay master.

// File: rtl/brq_pkg.sv
package brq_pkg;
  typedef enum logic [1:0] {
    PM_RUN    = 2'd0,
    PM_FREEZE = 2'd1,
    PM_DROP   = 2'd2
  } req_mode_e;

  function automatic req_mode_e req_mode(input logic stop_i, input logic wait_i,
                                         input logic hold_i);
    if (!(stop_i || wait_i)) return PM_RUN;
    return hold_i ? PM_FREEZE : PM_DROP;
  endfunction
endpackage

// File: rtl/brq_req_gen.sv
module brq_req_gen #(
  parameter int NUM_XSRC = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_XSRC-1:0] xacc_req,
  input  logic                req_hold,
  input  logic                core_stop,
  input  logic                core_wait,
  output logic                any_xacc,
  output logic                req_q
);
  import brq_pkg::*;

  req_mode_e mode;
  logic      req_d;

  assign any_xacc = |xacc_req;
  assign mode     = req_mode(core_stop, core_wait, req_hold);

  always_comb begin
    unique case (mode)
      PM_FREEZE: req_d = req_q;
      PM_DROP:   req_d = 1'b0;
      default:   req_d = any_xacc | req_hold;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end
endmodule

// File: rtl/brq_owner_track.sv
module brq_owner_track (
  input  logic clk,
  input  logic rst_n,
  input  logic req_q,
  input  logic bus_grant,
  output logic master_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               master_q <= 1'b0;
    else if (!bus_grant)      master_q <= 1'b0;
    else if (req_q)           master_q <= 1'b1;
  end
endmodule

// File: rtl/brq_park_detect.sv
module brq_park_detect (
  input  logic master_q,
  input  logic req_q,
  input  logic any_xacc,
  output logic parked,
  output logic go
);
  assign parked = master_q & ~req_q & ~any_xacc;
  assign go     = master_q & any_xacc;
endmodule

// File: rtl/brq_ctrl.sv
module brq_ctrl #(
  parameter int NUM_XSRC = 4,
  parameter int NUM_ISRC = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_XSRC-1:0] xacc_req,
  input  logic [NUM_ISRC-1:0] iacc_req,
  input  logic                req_hold,
  input  logic                bus_grant,
  input  logic                core_stop,
  input  logic                core_wait,
  output logic                bus_req,
  output logic                bus_master,
  output logic                bus_parked,
  output logic                xacc_go
);
  logic any_xacc;
  logic req_q;
  logic master_q;
  logic iacc_unused;

  // Internal-bus activity is deliberately kept away from the request path.
  assign iacc_unused = |iacc_req;

  brq_req_gen #(.NUM_XSRC(NUM_XSRC)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .xacc_req  (xacc_req),
    .req_hold  (req_hold),
    .core_stop (core_stop),
    .core_wait (core_wait),
    .any_xacc  (any_xacc),
    .req_q     (req_q)
  );

  brq_owner_track u_own (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_q     (req_q),
    .bus_grant (bus_grant),
    .master_q  (master_q)
  );

  brq_park_detect u_park (
    .master_q (master_q),
    .req_q    (req_q),
    .any_xacc (any_xacc),
    .parked   (bus_parked),
    .go       (xacc_go)
  );

  assign bus_req    = req_q;
  assign bus_master = master_q;
endmodule

// File: rtl/brq_ctrl_chk.sv
module brq_ctrl_chk #(
  parameter int NUM_XSRC = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_XSRC-1:0] xacc_req,
  input logic                req_hold,
  input logic                bus_grant,
  input logic                core_stop,
  input logic                core_wait,
  input logic                bus_req,
  input logic                bus_master,
  input logic                bus_parked,
  input logic                xacc_go
);
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |-> (!bus_req && !bus_master));

  p_run_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_stop && !core_wait) |=> (bus_req == $past((|xacc_req) || req_hold)));

  p_hold_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_stop && !core_wait && req_hold) |=> bus_req);

  p_lowpwr_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((core_stop || core_wait) && !req_hold) |=> !bus_req);

  p_lowpwr_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((core_stop || core_wait) && req_hold) |=> $stable(bus_req));

  p_grant_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant && bus_req) |=> bus_master);

  p_grant_loss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_grant |=> !bus_master);

  p_park_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_master && bus_grant) |=> bus_master);

  p_parked_def_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_parked |-> (bus_master && !bus_req && !(|xacc_req)));

  p_go_def_r11: assert property (@(posedge clk) disable iff (!rst_n)
    xacc_go |-> (bus_master && (|xacc_req)));
endmodule

bind brq_ctrl brq_ctrl_chk #(.NUM_XSRC(NUM_XSRC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .xacc_req   (xacc_req),
  .req_hold   (req_hold),
  .bus_grant  (bus_grant),
  .core_stop  (core_stop),
  .core_wait  (core_wait),
  .bus_req    (bus_req),
  .bus_master (bus_master),
  .bus_parked (bus_parked),
  .xacc_go    (xacc_go)
);

// File: tb/brq_ctrl_test.sv
`timescale 1ns/1ps
module brq_ctrl_test;
  localparam int NX = 4;
  localparam int NI = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NX-1:0] xacc_req = '0;
  logic [NI-1:0] iacc_req = '0;
  logic          req_hold = 1'b0;
  logic          bus_grant = 1'b0;
  logic          core_stop = 1'b0;
  logic          core_wait = 1'b0;
  logic          bus_req, bus_master, bus_parked, xacc_go;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  finished = 1'b0;
  logic m_req = 1'b0;
  logic m_mst = 1'b0;

  always #5 clk = ~clk;

  brq_ctrl #(.NUM_XSRC(NX), .NUM_ISRC(NI)) uut (
    .clk(clk), .rst_n(rst_n), .xacc_req(xacc_req), .iacc_req(iacc_req),
    .req_hold(req_hold), .bus_grant(bus_grant), .core_stop(core_stop),
    .core_wait(core_wait), .bus_req(bus_req), .bus_master(bus_master),
    .bus_parked(bus_parked), .xacc_go(xacc_go)
  );

  function automatic logic next_req(logic cur, logic [NX-1:0] x, logic h, logic s, logic w);
    if (s || w) return h ? cur : 1'b0;
    return (|x) || h;
  endfunction

  function automatic logic next_mst(logic cur, logic rq, logic g);
    if (!g) return 1'b0;
    if (rq) return 1'b1;
    return cur;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one cycle of inputs, check outputs against the model, then advance.
  task automatic step(logic [NX-1:0] x, logic [NI-1:0] i, logic h, logic g,
                      logic s, logic w, logic rn);
    string rtag;
    logic  nr, nm;
    @(negedge clk);
    xacc_req = x; iacc_req = i; req_hold = h; bus_grant = g;
    core_stop = s; core_wait = w; rst_n = rn;
    #1;
    if (!rn) begin
      m_req = 1'b0; m_mst = 1'b0;
      check("R1 bus_req", bus_req, 1'b0);
      check("R1 bus_master", bus_master, 1'b0);
      check("R1 bus_parked", bus_parked, 1'b0);
      check("R1 xacc_go", xacc_go, 1'b0);
    end else begin
      check("R7 R8 R9 bus_master", bus_master, m_mst);
      check("R10 bus_parked", bus_parked, m_mst && !m_req && !(|x));
      check("R11 xacc_go", xacc_go, m_mst && (|x));
      nr = next_req(m_req, x, h, s, w);
      nm = next_mst(m_mst, m_req, g);
      @(posedge clk);
      #1;
      if (s || w)              rtag = h ? "R6 bus_req" : "R5 bus_req";
      else if (h && x == '0)   rtag = "R4 bus_req";
      else if (i != '0)        rtag = "R3 bus_req";
      else                     rtag = "R2 bus_req";
      if (rst_n) check(rtag, bus_req, nr);
      m_req = nr; m_mst = nm;
      return;
    end
    @(posedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin : stim
    int seed;
    seed = $urandom(32'd20240611);
    // R1: reset state
    step('0, '1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    step('0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R3: internal traffic only
    step('0, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    step('0, 4'h5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    // R2 then R7: request, grant
    step(4'h2, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    step(4'h2, '0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    step(4'h2, '0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    // R9/R10: access done, grant kept -> parked
    step('0, 4'h3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    step('0, '0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    step('0, '0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    // R11: new access while parked goes at once
    step(4'h8, '0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    step('0, '0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    // R8: grant falls
    step('0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    step('0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    // R4: hold with nothing pending
    step('0, '0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    step('0, '0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    // R6: stop and wait with hold keep the request
    step('0, '0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    step('0, '0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    // R5: drop hold in stop
    step(4'h1, '0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    step(4'h1, '0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    // R6 with request low stays low
    step(4'h1, '0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    // Master, then reset mid-run (R1)
    step(4'h1, '0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    step(4'h1, '0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    step(4'h1, '0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    step(4'h1, '0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    step(4'h1, '0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    // Constrained random phase
    for (int n = 0; n < 4000; n++) begin
      logic [NX-1:0] rx;
      logic          rg, rh, rs, rw, rr;
      rx = ($urandom_range(0, 2) == 0) ? NX'($urandom) : '0;
      rg = ($urandom_range(0, 9) < 7);
      rh = ($urandom_range(0, 7) == 0);
      rs = ($urandom_range(0, 11) == 0);
      rw = ($urandom_range(0, 11) == 0);
      rr = ($urandom_range(0, 299) != 0);
      step(rx, NI'($urandom), rh, rg, rs, rw, rr);
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule